// File: doc/BRIEF.md
# Dual-Path Programmable Feedback Divider

This block is the feedback divider of a radio frequency synthesizer. The block has two local-oscillator paths, a low-band (AM) path and a high-band (FM) path. Each path is presented as a one-cycle clock-enable tick in a single fast system clock domain. The ticks of the selected path pass through that path's prescaler. The prescaled counts then feed a 14-bit down counter that divides by its programmed word plus one. Each completed division gives a one-cycle comparison pulse for the phase detector that follows.

The controlling logic presents a divide word and a band-select bit at any time. The divider takes both only at the end of a division period, so no comparison interval is ever shortened. When the band changes, the prescaler of the newly selected path starts counting from zero. Ticks on the path that is not selected are ignored.

Top module: `fbdiv_dualpath`

## Requirements
- R1: Between two consecutive `div_pulse` outputs there are exactly (N+1)·P ticks of the applied path, where N is the applied divide word and P is that path's prescale ratio.
- R2: The low-band path (`band_fm` = 0) uses a prescale ratio of 8.
- R3: The high-band path (`band_fm` = 1) uses a prescale ratio of 64 with the default modulus setting (FM_MOD = 0); FM_MOD = 1 selects 65.
- R4: Ticks of the path that is not applied have no effect on the count or on `div_pulse`.
- R5: `div_word` and `band_fm` are sampled only in the cycle that follows the terminal tick of a period, and they govern the next period. Changes at any other time have no effect on the current period.
- R6: `div_pulse` is high for exactly one cycle, two cycles after the cycle that carries the terminal tick of a period.
- R7: After a band change, the prescaler of the new path starts at zero. Ticks of the new path count from the sampling cycle onward.
- R8: A divide word of 0 gives one `div_pulse` per prescaled count (divide by 1).
- R9: During and after synchronous reset `div_pulse` is low, the low-band path is applied and the counter is at zero. The first pulse therefore follows 8 low-band ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| am_tick | input | 1 | Low-band oscillator clock enable, one cycle per input edge |
| fm_tick | input | 1 | High-band oscillator clock enable, one cycle per input edge |
| band_fm | input | 1 | Band request: 1 high band, 0 low band |
| div_word | input | 14 | Requested divide word N (divide by N+1) |
| div_pulse | output | 1 | Registered one-cycle comparison pulse |

## Verification
The hardest case to reach from the ports is a band or word change in the single sampling cycle between a terminal tick and the output pulse. That case needs a tick of the new path in the same cycle. The stimulus drives both tick lines at random on every cycle and toggles the band and the word at random instants. Over thousands of periods these changes land on the sampling cycle many times. A reference model in the bench keeps a two-cycle history of the inputs, so it knows which values each period must have taken.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;
  typedef enum logic {
    BAND_AM = 1'b0,
    BAND_FM = 1'b1
  } band_e;

  function automatic int unsigned cnt_width(input int unsigned depth);
    return (depth < 2) ? 1 : $clog2(depth);
  endfunction
endpackage

// File: rtl/lo_prescaler.sv
module lo_prescaler #(
  parameter int unsigned DIV = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic tick,
  output logic pre_pulse
);
  localparam int unsigned CW = fbdiv_pkg::cnt_width(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      phase_q   <= '0;
      pre_pulse <= 1'b0;
    end else begin
      pre_pulse <= tick && (phase_q == LAST);
      if (tick) begin
        phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
      end
    end
  end

  a_r7_idle_cleared: assert property (@(posedge clk) disable iff (rst)
    !en |=> (phase_q == '0) && !pre_pulse);
  a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    pre_pulse |-> (phase_q == '0));
endmodule

// File: rtl/prog_counter.sv
module prog_counter
  import fbdiv_pkg::*;
#(
  parameter int unsigned NW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic [NW-1:0] word_in,
  input  band_e         band_in,
  output band_e         band_act,
  output logic          load,
  output logic          pulse
);
  logic [NW-1:0] cnt_q;

  assign load = step && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      band_act <= BAND_AM;
      pulse    <= 1'b0;
    end else begin
      pulse <= load;
      if (load) begin
        cnt_q    <= word_in;
        band_act <= band_in;
      end else if (step) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  a_r1_count_down: assert property (@(posedge clk) disable iff (rst)
    (step && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  a_r5_band_held: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(band_act));
  a_r5_word_taken: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == $past(word_in)));
  a_r6_pulse_follows_step: assert property (@(posedge clk) disable iff (rst)
    pulse |-> $past(step));
endmodule

// File: rtl/fbdiv_dualpath.sv
module fbdiv_dualpath
  import fbdiv_pkg::*;
#(
  parameter int unsigned NW      = 14,
  parameter int unsigned AM_DIV  = 8,
  parameter int unsigned FM_BASE = 64,
  parameter int unsigned FM_MOD  = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          am_tick,
  input  logic          fm_tick,
  input  logic          band_fm,
  input  logic [NW-1:0] div_word,
  output logic          div_pulse
);
  localparam int unsigned NPATH  = 2;
  localparam int unsigned FM_DIV = FM_BASE + FM_MOD;

  band_e      band_act;
  band_e      band_req;
  logic       load;
  logic       sel_fm;
  logic       step;
  logic [NPATH-1:0] path_tick;
  logic [NPATH-1:0] path_en;
  logic [NPATH-1:0] path_pre;

  assign band_req = band_e'(band_fm);
  // Look ahead to the requested band in the sampling cycle so that
  // a new-path tick arriving in that same cycle is not lost.
  assign sel_fm   = load ? band_fm : (band_act == BAND_FM);

  assign path_tick = {fm_tick, am_tick};
  assign path_en   = {sel_fm, !sel_fm};

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    localparam int unsigned PDIV = (p == 0) ? AM_DIV : FM_DIV;
    lo_prescaler #(.DIV(PDIV)) u_pre (
      .clk       (clk),
      .rst       (rst),
      .en        (path_en[p]),
      .tick      (path_tick[p]),
      .pre_pulse (path_pre[p])
    );
  end

  assign step = |path_pre;

  prog_counter #(.NW(NW)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .step     (step),
    .word_in  (div_word),
    .band_in  (band_req),
    .band_act (band_act),
    .load     (load),
    .pulse    (div_pulse)
  );

  initial begin
    a_r3_mod_range: assert (FM_MOD <= 1 && AM_DIV >= 2 && FM_BASE >= 2);
  end

  a_r4_one_path: assert property (@(posedge clk) disable iff (rst)
    $onehot0(path_pre));
  a_r6_single_cycle: assert property (@(posedge clk) disable iff (rst)
    div_pulse |=> !div_pulse);
  a_r9_reset_quiet: assert property (@(posedge clk)
    rst |=> !div_pulse);
endmodule

// File: tb/sim_fbdiv_dualpath.sv
module sim_fbdiv_dualpath;
  localparam int NW = 14;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          am_tick = 1'b0;
  logic          fm_tick = 1'b0;
  logic          band_fm = 1'b0;
  logic [NW-1:0] div_word = '0;
  logic          div_pulse;

  int checks = 0;
  int errors = 0;
  int phase_pulses = 0;
  string tag = "R9";

  always #2.5 clk = ~clk;

  fbdiv_dualpath u0 (
    .clk(clk), .rst(rst), .am_tick(am_tick), .fm_tick(fm_tick),
    .band_fm(band_fm), .div_word(div_word), .div_pulse(div_pulse)
  );

  function automatic int exp_period(int n, bit fm);
    return (n + 1) * (fm ? 64 : 8);
  endfunction

  // Reference model: history of the two previous cycles' inputs.
  bit h1_am, h1_fm, h1_band, h2_am, h2_fm;
  int h1_word;
  int acc;
  int n_exp;
  bit b_exp;
  bit prev_pulse;

  always @(negedge clk) begin
    if (rst) begin
      checks++;
      if (div_pulse !== 1'b0) begin
        errors++;
        $display("FAIL R9 pulse during reset: got %0b expected 0", div_pulse);
      end
      acc = 0; n_exp = 0; b_exp = 0; prev_pulse = 0;
      h1_am = 0; h1_fm = 0; h1_band = 0; h1_word = 0; h2_am = 0; h2_fm = 0;
    end else begin
      int tk;
      tk = b_exp ? int'(h2_fm) : int'(h2_am);
      if (div_pulse) begin
        checks++;
        phase_pulses++;
        if (acc + tk != exp_period(n_exp, b_exp)) begin
          errors++;
          $display("FAIL %s R1 period ticks: got %0d expected %0d (N=%0d band=%0b)",
                   tag, acc + tk, exp_period(n_exp, b_exp), n_exp, b_exp);
        end
        if (prev_pulse) begin
          errors++;
          $display("FAIL R6 pulse wider than one cycle: got 2 expected 1");
        end
        n_exp = h1_word;
        b_exp = h1_band;
        acc = 0;
      end else begin
        acc += tk;
      end
      prev_pulse = div_pulse;
      h2_am = h1_am; h2_fm = h1_fm;
      h1_am = am_tick; h1_fm = fm_tick; h1_band = band_fm; h1_word = int'(div_word);
    end
  end

  // Drive one cycle; pa/pf are tick probabilities in percent,
  // pw/pb chances per mille to change word/band.
  task automatic run(input int cycles, input int pa, input int pf,
                     input int pw, input int pb, input int nmax);
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk); #1;
      am_tick = ($urandom_range(99, 0) < pa);
      fm_tick = ($urandom_range(99, 0) < pf);
      if ($urandom_range(999, 0) < pw) div_word = NW'($urandom_range(nmax, 0));
      if ($urandom_range(999, 0) < pb) band_fm = ~band_fm;
    end
  endtask

  task automatic end_phase();
    checks++;
    if (phase_pulses == 0) begin
      errors++;
      $display("FAIL %s no pulse in phase: got 0 expected >0", tag);
    end
    phase_pulses = 0;
  endtask

  task automatic setup(input string t, input bit b, input int n);
    @(posedge clk); #1;
    tag = t; band_fm = b; div_word = NW'(n);
  endtask

  initial begin
    void'($urandom(32'd7215));
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    // R9: first period after reset is 8 low-band ticks
    run(40, 100, 100, 0, 0, 0);
    end_phase();
    setup("R8", 0, 0);       run(300, 60, 60, 0, 0, 0);    end_phase();
    setup("R2", 0, 9);       run(600, 70, 70, 0, 0, 0);    end_phase();
    setup("R3", 1, 0);       run(900, 50, 80, 0, 0, 0);    end_phase();
    setup("R4", 1, 2);       run(1500, 100, 60, 0, 0, 0);  end_phase();
    setup("R7", 0, 1);       run(20000, 70, 70, 0, 40, 3); end_phase();
    setup("R5", 0, 5);       run(40000, 65, 75, 60, 15, 20); end_phase();
    setup("R1", 0, 1000);    run(9000, 100, 30, 0, 0, 0);  end_phase();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule